// File: doc/BRIEF.md
# Committed-Ratio Clock Enable Divider Bank

This block derives ten clock-enable streams from one fast parent clock. Each stream emits a single-cycle enable pulse once every N parent cycles, where N comes from a 4-bit ratio code. The codes are packed into two 32-bit control registers on a simple register bus with address, write data, write strobe and combinational read data.

Software writes codes into shadow copies of the registers. Nothing changes at the outputs until a commit bit is written. The commit applies every staged code from both registers as one set. Each channel takes its new ratio only when its current output period ends, so no enable interval is ever cut short or stretched.

Each channel also has a mask of the codes it accepts. A commit that offers a channel a reserved, undefined or masked code leaves that channel at its previous ratio, and it sets a sticky error flag.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every channel is at code 0 (divide by 2). Both registers read 0, including the commit bit and the error bit. The first enable pulse of every channel appears in the second cycle after reset is released.
- R2: Codes 0 to 11 select divisors 2, 3, 4, 6, 8, 12, 16, 18, 24, (reserved), 36 and 48 respectively. An active channel asserts its enable for exactly one cycle in every N cycles.
- R3: Word address 0 is register A. It holds channels 0..4 as 4-bit codes at bit offsets 20, 16, 8, 4 and 0. Word address 1 is register B. It holds channels 5..9 at bit offsets 24, 20, 16, 12 and 4. Reads return the staged codes. All other bits read 0, except bits 31 and 30 of register B.
- R4: Writing codes without the commit bit changes only the staged codes. The enable outputs keep their existing ratios.
- R5: Writing register B with bit 31 set commits the staged codes of both registers, including the codes carried by that same write. Bit 31 of register B reads 1 from the cycle after the commit while any channel has not yet switched. It returns to 0 once all channels have switched.
- R6: A channel with a committed ratio keeps its old ratio until the cycle after its next enable pulse. It then starts a full new period, so no interval between pulses is shorter or longer than the old or the new divisor.
- R7: At a commit, a channel whose staged code is 9 or 12..15, or is excluded by that channel's mask, keeps its previous ratio. The other channels still switch. With the default masks, channels 1 and 5 reject code 10 and all others accept codes 0..11 except 9.
- R8: The error flag is bit 30 of register B. It is set by any commit that rejects a channel. It stays set until reset, and writes to bit 30 have no effect on it.
- R9: A commit written while a previous commit is still pending is ignored. The write still updates the staged codes, which a later commit applies.
- R10: Writes to word addresses other than 0 and 1 change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast parent clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (2) | Word address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| clk_en | output | 10 | One enable pulse stream per channel |

## Verification
The bench builds the block with its default parameters. These are a 2-bit word address, which leaves addresses 2 and 3 unused and so makes the ignored-access case reachable. The default masks make channels 1 and 5 reject code 10, so one commit can mix accepted and rejected channels. Because the divisors reach 48, a long ratio can still hold a commit pending while a second commit is attempted, which exercises the ignored-kick case.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int REG_W       = 32;
    localparam int CODE_W      = 4;
    localparam int NUM_CODES   = 12;
    localparam int RSV_CODE    = 9;
    localparam int CNT_W       = 6;
    localparam int CH_PER_REG  = 5;
    localparam int NUM_CH      = 2 * CH_PER_REG;
    localparam int MASK_W      = NUM_CODES;
    localparam int COMMIT_BIT  = 31;
    localparam int ERROR_BIT   = 30;
    localparam int REG_A_IDX   = 0;
    localparam int REG_B_IDX   = 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Per-channel commit request from the register file to the channels
    typedef struct packed {
        logic [NUM_CH-1:0] load;
        code_t [NUM_CH-1:0] code;
    } commit_t;

    // Channels 1 and 5 refuse the divide-by-36 code
    localparam logic [NUM_CH-1:0][MASK_W-1:0] DEFAULT_MASK = {
        12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 12'hBFF,
        12'hFFF, 12'hFFF, 12'hFFF, 12'hBFF, 12'hFFF
    };

    // Bit offset of a channel's code inside its register
    function automatic int field_lsb(input int ch);
        case (ch)
            0: return 20;
            1: return 16;
            2: return 8;
            3: return 4;
            4: return 0;
            5: return 24;
            6: return 20;
            7: return 16;
            8: return 12;
            default: return 4;
        endcase
    endfunction

    function automatic logic in_reg_b(input int ch);
        return ch >= CH_PER_REG;
    endfunction

    // Ratio code to divisor; zero marks no divisor
    function automatic cnt_t code_to_div(input code_t code);
        case (code)
            4'd0:  return cnt_t'(2);
            4'd1:  return cnt_t'(3);
            4'd2:  return cnt_t'(4);
            4'd3:  return cnt_t'(6);
            4'd4:  return cnt_t'(8);
            4'd5:  return cnt_t'(12);
            4'd6:  return cnt_t'(16);
            4'd7:  return cnt_t'(18);
            4'd8:  return cnt_t'(24);
            4'd10: return cnt_t'(36);
            4'd11: return cnt_t'(48);
            default: return cnt_t'(0);
        endcase
    endfunction

    function automatic logic code_legal(input code_t code, input logic [MASK_W-1:0] mask);
        logic [15:0] wide_mask;
        wide_mask = {{(16-MASK_W){1'b0}}, mask};
        return (int'(code) < NUM_CODES) && (int'(code) != RSV_CODE) && wide_mask[code];
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter logic [NUM_CH-1:0][MASK_W-1:0] CH_MASK = DEFAULT_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wr,
    input  logic [NUM_CH-1:0] busy,
    output logic [REG_W-1:0]  rdata,
    output commit_t           commit,
    output logic              err
);

    code_t [NUM_CH-1:0] shadow_q;
    code_t [NUM_CH-1:0] shadow_d;
    logic  [NUM_CH-1:0] legal;
    logic               sel_a;
    logic               sel_b;
    logic               kick_req;
    logic               err_q;

    assign sel_a = (addr == ADDR_W'(REG_A_IDX));
    assign sel_b = (addr == ADDR_W'(REG_B_IDX));

    // Staged codes merged with the write of this cycle
    always_comb begin
        shadow_d = shadow_q;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (wr && ((sel_a && !in_reg_b(ch)) || (sel_b && in_reg_b(ch)))) begin
                shadow_d[ch] = wdata[field_lsb(ch) +: CODE_W];
            end
        end
    end

    // A commit is accepted only when no channel is still switching
    assign kick_req = wr && sel_b && wdata[COMMIT_BIT] && !(|busy);

    always_comb begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            legal[ch]       = code_legal(shadow_d[ch], CH_MASK[ch]);
            commit.load[ch] = kick_req && legal[ch];
            commit.code[ch] = shadow_d[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            err_q    <= 1'b0;
        end else begin
            shadow_q <= shadow_d;
            if (kick_req && !(&legal)) begin
                err_q <= 1'b1;
            end
        end
    end

    assign err = err_q;

    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if ((sel_a && !in_reg_b(ch)) || (sel_b && in_reg_b(ch))) begin
                rdata[field_lsb(ch) +: CODE_W] = shadow_q[ch];
            end
        end
        if (sel_b) begin
            rdata[COMMIT_BIT] = |busy;
            rdata[ERROR_BIT]  = err_q;
        end
    end

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
    import clkdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  code_t load_code,
    output logic  en,
    output logic  busy
);

    code_t act_code_q;
    code_t pend_code_q;
    logic  pend_q;
    cnt_t  cnt_q;
    cnt_t  last_cnt;
    logic  period_end;

    assign last_cnt   = code_to_div(act_code_q) - cnt_t'(1);
    assign period_end = (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_code_q  <= '0;
            pend_code_q <= '0;
            pend_q      <= 1'b0;
            cnt_q       <= '0;
        end else begin
            if (period_end) begin
                cnt_q <= '0;
                if (pend_q) begin
                    // New ratio starts with a full period
                    act_code_q <= pend_code_q;
                    pend_q     <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q + cnt_t'(1);
            end
            if (load) begin
                pend_q      <= 1'b1;
                pend_code_q <= load_code;
            end
        end
    end

    assign en   = period_end;
    assign busy = pend_q;

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter logic [NUM_CH-1:0][MASK_W-1:0] CH_MASK = DEFAULT_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] clk_en
);

    commit_t           commit;
    logic [NUM_CH-1:0] chan_busy;
    logic              err_flag;

    clkdiv_regs #(
        .ADDR_W  (ADDR_W),
        .CH_MASK (CH_MASK)
    ) i_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .wr     (bus_wr),
        .busy   (chan_busy),
        .rdata  (bus_rdata),
        .commit (commit),
        .err    (err_flag)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        clkdiv_channel i_chan (
            .clk       (clk),
            .rst       (rst),
            .load      (commit.load[ch]),
            .load_code (commit.code[ch]),
            .en        (clk_en[ch]),
            .busy      (chan_busy[ch])
        );
    end

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
    import clkdiv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [NUM_CH-1:0] clk_en,
    input logic [NUM_CH-1:0] busy,
    input logic              err
);

    // R1: reset clears the error flag and any pending switch
    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (!err && busy == '0))
        else $error("reset did not clear state");

    // R8: the error flag is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst) err |=> err)
        else $error("error flag dropped");

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R2: every divisor is at least 2, so pulses never touch
        assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
            clk_en[i] |=> !clk_en[i])
            else $error("back-to-back enable on channel %0d", i);

        // R6: a pending switch survives until the period ends
        assert_hold_mid_period_R6: assert property (@(posedge clk) disable iff (rst)
            (busy[i] && !clk_en[i]) |=> busy[i])
            else $error("pending switch lost on channel %0d", i);

        // R6: a pending switch completes at the period end
        assert_switch_at_end_R6: assert property (@(posedge clk) disable iff (rst)
            (busy[i] && clk_en[i]) |=> !busy[i])
            else $error("switch missed period end on channel %0d", i);

        // R5: a switch only becomes pending through a register write
        assert_commit_from_write_R5: assert property (@(posedge clk) disable iff (rst)
            (busy[i] && !$past(busy[i])) |-> $past(bus_wr))
            else $error("pending switch without a write on channel %0d", i);
    end

endmodule

bind clkdiv_bank clkdiv_bank_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .bus_wr (bus_wr),
    .clk_en (clk_en),
    .busy   (chan_busy),
    .err    (err_flag)
);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_rdata;
    logic [9:0]  clk_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit compare_on = 0;

    // Reference model state
    int m_cnt[10];
    int m_div[10];
    int m_pdiv[10];
    bit m_pend[10];
    int m_shadow[10];
    int m_next[10];
    bit m_err;
    bit m_any;

    clkdiv_bank i_clkdiv_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .clk_en    (clk_en)
    );

    always #4 clk = ~clk;

    function automatic int tb_div(input int code);
        case (code)
            0: return 2;   1: return 3;   2: return 4;   3: return 6;
            4: return 8;   5: return 12;  6: return 16;  7: return 18;
            8: return 24;  10: return 36; 11: return 48;
            default: return 0;
        endcase
    endfunction

    function automatic int tb_lsb(input int ch);
        int offs[10] = '{20, 16, 8, 4, 0, 24, 20, 16, 12, 4};
        return offs[ch];
    endfunction

    function automatic bit tb_legal(input int ch, input int code);
        if (code > 11 || code == 9) return 0;
        if ((ch == 1 || ch == 5) && code == 10) return 0;
        return 1;
    endfunction

    function automatic bit any_pend();
        bit a = 0;
        for (int ch = 0; ch < 10; ch++) a |= m_pend[ch];
        return a;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        logic [31:0] v = '0;
        if (a == 0 || a == 1) begin
            for (int ch = 0; ch < 10; ch++)
                if ((ch >= 5) == (a == 1)) v |= 32'(m_shadow[ch]) << tb_lsb(ch);
            if (a == 1) begin
                v[31] = any_pend();
                v[30] = m_err;
            end
        end
        return v;
    endfunction

    task automatic model_reset();
        for (int ch = 0; ch < 10; ch++) begin
            m_cnt[ch] = 0; m_div[ch] = 2; m_pdiv[ch] = 2;
            m_pend[ch] = 0; m_shadow[ch] = 0;
        end
        m_err = 0;
    endtask

    initial model_reset();

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            m_any = any_pend();
            for (int ch = 0; ch < 10; ch++) begin
                m_next[ch] = m_shadow[ch];
                if (bus_wr && (bus_addr == 2'd0) && ch < 5)
                    m_next[ch] = int'((bus_wdata >> tb_lsb(ch)) & 32'hF);
                if (bus_wr && (bus_addr == 2'd1) && ch >= 5)
                    m_next[ch] = int'((bus_wdata >> tb_lsb(ch)) & 32'hF);
            end
            for (int ch = 0; ch < 10; ch++) begin
                if (m_cnt[ch] == m_div[ch] - 1) begin
                    m_cnt[ch] = 0;
                    if (m_pend[ch]) begin
                        m_div[ch] = m_pdiv[ch];
                        m_pend[ch] = 0;
                    end
                end else begin
                    m_cnt[ch]++;
                end
            end
            if (bus_wr && bus_addr == 2'd1 && bus_wdata[31] && !m_any) begin
                for (int ch = 0; ch < 10; ch++) begin
                    if (tb_legal(ch, m_next[ch])) begin
                        m_pend[ch] = 1;
                        m_pdiv[ch] = tb_div(m_next[ch]);
                    end else begin
                        m_err = 1;
                    end
                end
            end
            for (int ch = 0; ch < 10; ch++) m_shadow[ch] = m_next[ch];
        end
    end

    // Per-cycle comparison of every enable output (R2, R4, R6, R7)
    always @(negedge clk) begin
        if (compare_on && !rst) begin
            for (int ch = 0; ch < 10; ch++) begin
                checks++;
                if (clk_en[ch] !== (m_cnt[ch] == m_div[ch] - 1)) begin
                    fails++;
                    $display("FAIL R2/R6 channel %0d enable at cycle %0d: actual %b expected %b",
                             ch, cycles, clk_en[ch], (m_cnt[ch] == m_div[ch] - 1));
                end
            end
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = a;
        #1;
        e = exp_read(int'(a));
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s read addr %0d: actual %h expected %h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic wait_idle(input string tag);
        bit done = 0;
        for (int i = 0; i < 200 && !done; i++) begin
            @(negedge clk);
            bus_addr = 2'd1;
            #1;
            if (!bus_rdata[31]) done = 1;
        end
        checks++;
        if (!done || any_pend()) begin
            fails++;
            $display("FAIL %s commit bit did not clear: actual %b expected 0", tag, bus_rdata[31]);
        end
    endtask

    task automatic measure(input int ch, input int expn, input string tag);
        int n = 0;
        for (int i = 0; i < 100 && !clk_en[ch]; i++) @(negedge clk);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n++;
            if (clk_en[ch]) break;
        end
        checks++;
        if (n != expn) begin
            fails++;
            $display("FAIL %s channel %0d interval: actual %0d expected %0d", tag, ch, n, expn);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d: actual hang expected completion", cycles);
            finish_run();
        end
    end

    localparam logic [31:0] A_CODES = (32'd1 << 20) | (32'd2 << 16) | (32'd3 << 8) | (32'd4 << 4) | 32'd5;
    localparam logic [31:0] B_CODES = (32'd6 << 24) | (32'd7 << 20) | (32'd8 << 16) | (32'd10 << 12) | (32'd11 << 4);

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        compare_on = 1;

        // R1: reset state
        rd_check(2'd0, "R1");
        rd_check(2'd1, "R1");
        measure(0, 2, "R1");
        measure(9, 2, "R1");

        // R3, R4: staged codes read back but do not act
        wr_reg(2'd0, A_CODES);
        wr_reg(2'd1, B_CODES);
        rd_check(2'd0, "R3");
        rd_check(2'd1, "R3");
        repeat (60) @(negedge clk);
        measure(9, 2, "R4");
        measure(0, 2, "R4");

        // R5: commit of both registers, commit bit readback
        wr_reg(2'd1, B_CODES | 32'h8000_0000);
        rd_check(2'd1, "R5");
        wait_idle("R5");
        rd_check(2'd1, "R5");
        measure(0, 3, "R2");
        measure(4, 12, "R2");
        measure(7, 24, "R2");
        measure(8, 36, "R2");
        measure(9, 48, "R2");
        repeat (100) @(negedge clk);

        // R7: reserved, undefined and masked codes are rejected
        wr_reg(2'd0, (32'd9 << 20) | (32'd10 << 16) | (32'd13 << 8));
        wr_reg(2'd1, (32'd10 << 24) | 32'h8000_0000);
        rd_check(2'd1, "R7");
        wait_idle("R7");
        rd_check(2'd1, "R7");
        measure(0, 3, "R7");
        measure(1, 4, "R7");
        measure(2, 6, "R7");
        measure(5, 16, "R7");
        measure(3, 2, "R7");
        measure(9, 2, "R7");

        // R8: error flag sticky, unaffected by writes to its bit
        wr_reg(2'd1, 32'h4000_0000);
        rd_check(2'd1, "R8");
        wr_reg(2'd1, 32'h0);
        rd_check(2'd1, "R8");

        // R9: a second commit during a pending one is ignored
        wr_reg(2'd0, 32'd11 << 20);
        wr_reg(2'd1, 32'h8000_0000);
        wr_reg(2'd1, (32'd5 << 20) | 32'h8000_0000);
        rd_check(2'd1, "R9");
        wait_idle("R9");
        measure(6, 2, "R9");
        measure(0, 48, "R9");
        wr_reg(2'd1, (32'd5 << 20) | 32'h8000_0000);
        wait_idle("R9");
        measure(6, 12, "R9");

        // R10: unused addresses
        wr_reg(2'd2, 32'hFFFF_FFFF);
        wr_reg(2'd3, 32'hFFFF_FFFF);
        rd_check(2'd2, "R10");
        rd_check(2'd3, "R10");
        rd_check(2'd0, "R10");
        rd_check(2'd1, "R10");
        measure(6, 12, "R10");

        // R1: reset during operation
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_check(2'd0, "R1");
        rd_check(2'd1, "R1");
        measure(0, 2, "R1");
        measure(6, 2, "R1");

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule